// File: doc/BRIEF.md
# Page Write Buffer and Commit Sequencer

This block sits behind the byte-level receiver of a two-wire serial memory slave. Before any data arrives it takes the starting word address of a write command. It then gathers the data bytes of that command into a page latch that is one aligned page wide. A per-byte valid mask records which page offsets were actually received. When the bus STOP arrives, the latched bytes are copied into the storage array in a single timed write cycle. During that cycle the block raises a busy flag, and the slave uses this flag to hold back its acknowledges.

Within a command, only the page-offset bits of the address advance. Bytes beyond one page length wrap to the start of the same page and replace earlier latched bytes. The page-select bits never change. The write-protect input is looked at only at the STOP. A protected or empty command is dropped without a write cycle, so the slave can take the next command at once. The write cycle is modelled as a sweep of the page latch followed by a hold timer whose length is a parameter in system clocks.

Top module: `page_commit_ctrl`

## Requirements
- R1: After reset, busy and mem_we are low and word_ptr is zero.
- R2: A received byte is stored at the array address {page bits of word_ptr, offset bits of word_ptr} that word_ptr held when the byte arrived.
- R3: Each accepted byte advances only the low log2(PAGE_BYTES) bits of word_ptr, wrapping from PAGE_BYTES-1 to 0. The page bits above them are unchanged.
- R4: When more than PAGE_BYTES bytes are sent, a later byte replaces the earlier byte at the same offset, and only the last value is written to the array.
- R5: A write cycle drives mem_we exactly once for each distinct received offset. It drives it for no other offset, so the other locations in the page keep their old contents.
- R6: Nothing is written before the STOP. busy becomes high in the cycle after an accepted STOP that starts a commit.
- R7: A commit holds busy high for exactly PAGE_BYTES + WRITE_CYCLES clock cycles, and all of its mem_we pulses fall inside that window.
- R8: If wp_in is high when the STOP is accepted, no write happens and busy stays low.
- R9: A change of wp_in after the STOP has been accepted does not alter a commit that is already running.
- R10: A STOP that follows only an address load, with no data bytes, starts no write cycle.
- R11: While busy is high, addr_load, byte_stb and stop_stb are ignored. word_ptr, the array and the busy length are unaffected by them.
- R12: When a write command ends, word_ptr holds the location after the last byte written, wrapped within its page.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_load | input | 1 | Strobe: load start_addr and open a new write command |
| start_addr | input | ADDR_W | Starting word address of the command |
| byte_stb | input | 1 | Strobe: one data byte received |
| byte_data | input | 8 | Received data byte |
| stop_stb | input | 1 | Strobe: bus STOP seen |
| wp_in | input | 1 | Write-protect level, high means protected |
| mem_we | output | 1 | Array write enable, one byte per pulse |
| mem_addr | output | ADDR_W | Array write address |
| mem_wdata | output | 8 | Array write data |
| busy | output | 1 | Write cycle in progress; the slave withholds ACKs |
| word_ptr | output | ADDR_W | Current internal address pointer |

## Verification
The assertions assume that the three strobes are single-cycle pulses and that at most one of them is high in any cycle. This matches how a byte receiver reports bus events. The bench drives every strobe for exactly one clock from a task, one event at a time, so the assumption always holds. This is true even when it fires strobes at a busy block on purpose. Random commands draw the start address, the byte count (zero to beyond one page) and the byte values from a seeded generator. The protect level and its toggling are driven only in directed cases.

// File: rtl/pgw_pkg.sv
// Shared types for the page write buffer.
package pgw_pkg;
    // Commit sequencer phases: idle, latch sweep, timed hold.
    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_SCAN = 2'd1,
        SEQ_HOLD = 2'd2
    } seq_state_t;
endpackage

// File: rtl/pgw_latch.sv
// Page latch: one byte register per page offset plus a valid mask.
// Assumes clr and wr_en are not both high in the same cycle (clr wins).
module pgw_latch #(
    parameter int PAGE_BYTES = 32,
    parameter int OFS_W      = $clog2(PAGE_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [OFS_W-1:0] wr_idx,
    input  logic [7:0]       wr_data,
    input  logic             clr,
    input  logic [OFS_W-1:0] rd_idx,
    output logic [7:0]       rd_data,
    output logic             rd_valid,
    output logic             any_valid
);
    logic [7:0]            store [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] vmask;

    // Byte storage: the newest byte for an offset replaces the older one.
    always_ff @(posedge clk) begin
        if (wr_en && !clr) store[wr_idx] <= wr_data;
    end

    // Valid mask: set on receipt, cleared when a command opens or ends.
    always_ff @(posedge clk) begin
        if (!rst_n)     vmask <= '0;
        else if (clr)   vmask <= '0;
        else if (wr_en) vmask[wr_idx] <= 1'b1;
    end

    assign rd_data   = store[rd_idx];
    assign rd_valid  = vmask[rd_idx];
    assign any_valid = |vmask;

    // A write marks its offset valid (R5).
    p_mark_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clr) |=> vmask[$past(wr_idx)]);
endmodule

// File: rtl/pgw_pointer.sv
// Word address pointer. A load replaces the whole address. A step advances
// only the in-page offset bits and wraps inside the page.
module pgw_pointer #(
    parameter int ADDR_W = 13,
    parameter int OFS_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              step,
    output logic [ADDR_W-1:0] ptr
);
    // Pointer register with page-local increment.
    always_ff @(posedge clk) begin
        if (!rst_n)    ptr <= '0;
        else if (load) ptr <= load_addr;
        else if (step) ptr[OFS_W-1:0] <= ptr[OFS_W-1:0] + 1'b1;
    end

    // Stepping never alters the page bits (R3).
    p_page_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> $stable(ptr[ADDR_W-1:OFS_W]));
endmodule

// File: rtl/pgw_sequencer.sv
// Commit sequencer. On start it sweeps every page offset once (one cycle
// each), then holds for WRITE_CYCLES clocks. busy covers both phases.
// Assumes PAGE_BYTES is a power of two and WRITE_CYCLES >= 1.
module pgw_sequencer
    import pgw_pkg::*;
#(
    parameter int PAGE_BYTES   = 32,
    parameter int OFS_W        = $clog2(PAGE_BYTES),
    parameter int WRITE_CYCLES = 500000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             busy,
    output logic             scanning,
    output logic [OFS_W-1:0] scan_idx,
    output logic             done
);
    localparam int               TMR_W    = $clog2(WRITE_CYCLES + 1);
    localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(WRITE_CYCLES - 1);
    localparam logic [OFS_W-1:0] IDX_LAST = OFS_W'(PAGE_BYTES - 1);

    seq_state_t       state;
    logic [TMR_W-1:0] tmr;

    // Phase register, sweep index and hold timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= SEQ_IDLE;
            scan_idx <= '0;
            tmr      <= '0;
        end else begin
            case (state)
                SEQ_IDLE: if (start) begin
                    state    <= SEQ_SCAN;
                    scan_idx <= '0;
                end
                SEQ_SCAN: begin
                    scan_idx <= scan_idx + 1'b1;
                    if (scan_idx == IDX_LAST) begin
                        state <= SEQ_HOLD;
                        tmr   <= '0;
                    end
                end
                SEQ_HOLD: begin
                    if (tmr == TMR_LAST) state <= SEQ_IDLE;
                    else                 tmr   <= tmr + 1'b1;
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    assign busy     = (state != SEQ_IDLE);
    assign scanning = (state == SEQ_SCAN);
    assign done     = (state == SEQ_HOLD) && (tmr == TMR_LAST);

    // The hold timer never passes its limit (R7).
    p_timer_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_HOLD) |-> (tmr <= TMR_LAST));
    // The sweep always hands over to the hold phase (R7).
    p_sweep_to_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (scanning && scan_idx == IDX_LAST) |=> (state == SEQ_HOLD));
endmodule

// File: rtl/page_commit_ctrl.sv
// Page write buffer and commit sequencer for a serial memory slave.
// Collects a write command's data bytes into a page latch and commits them
// on STOP, unless write-protect is high at that moment or no byte arrived.
// Assumes the strobes are single-cycle and mutually exclusive.
module page_commit_ctrl #(
    parameter int ADDR_W       = 13,
    parameter int PAGE_BYTES   = 32,
    parameter int WRITE_CYCLES = 500000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_load,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              byte_stb,
    input  logic [7:0]        byte_data,
    input  logic              stop_stb,
    input  logic              wp_in,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              busy,
    output logic [ADDR_W-1:0] word_ptr
);
    localparam int OFS_W = $clog2(PAGE_BYTES);

    logic             accept, ld, bw, st, start, clr;
    logic             any_valid, rd_valid, scanning, done;
    logic [OFS_W-1:0] scan_idx;
    logic [7:0]       rd_data;

    // Bus events count only while no commit is running.
    assign accept = !busy;
    assign ld     = addr_load & accept;
    assign bw     = byte_stb  & accept;
    assign st     = stop_stb  & accept;
    assign start  = st & any_valid & !wp_in;
    assign clr    = ld | (st & !start) | done;

    pgw_pointer #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_ptr (
        .clk(clk), .rst_n(rst_n), .load(ld), .load_addr(start_addr),
        .step(bw), .ptr(word_ptr)
    );

    pgw_latch #(.PAGE_BYTES(PAGE_BYTES), .OFS_W(OFS_W)) u_latch (
        .clk(clk), .rst_n(rst_n), .wr_en(bw), .wr_idx(word_ptr[OFS_W-1:0]),
        .wr_data(byte_data), .clr(clr), .rd_idx(scan_idx),
        .rd_data(rd_data), .rd_valid(rd_valid), .any_valid(any_valid)
    );

    pgw_sequencer #(.PAGE_BYTES(PAGE_BYTES), .OFS_W(OFS_W),
                    .WRITE_CYCLES(WRITE_CYCLES)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
        .scanning(scanning), .scan_idx(scan_idx), .done(done)
    );

    // Array port: one write per valid offset during the sweep.
    assign mem_we    = scanning & rd_valid;
    assign mem_addr  = {word_ptr[ADDR_W-1:OFS_W], scan_idx};
    assign mem_wdata = rd_data;

    // A commit begins only from an unprotected STOP (R6, R9).
    p_busy_needs_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(stop_stb) && !$past(wp_in)));
    // A protected STOP never starts a commit (R8).
    p_wp_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_stb && !busy && wp_in) |=> !busy);
    // A STOP with an empty latch never starts a commit (R10).
    p_empty_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_stb && !busy && !any_valid) |=> !busy);
    // The pointer is frozen while a commit runs (R11).
    p_ptr_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(word_ptr));
endmodule

// File: tb/page_commit_ctrl_tb.sv
`timescale 1ns/1ps
module page_commit_ctrl_tb;
    localparam int AW = 13;
    localparam int PB = 32;
    localparam int WC = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          addr_load = 1'b0, byte_stb = 1'b0, stop_stb = 1'b0, wp_in = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic [7:0]    byte_data = '0;
    logic          mem_we, busy;
    logic [AW-1:0] mem_addr, word_ptr;
    logic [7:0]    mem_wdata;

    int checks = 0, fails = 0;
    int wr_count = 0, busy_cnt = 0;
    logic [7:0] dut_mem [1 << AW];
    logic [7:0] exp_mem [1 << AW];

    always #2.5 clk = ~clk;

    page_commit_ctrl #(.ADDR_W(AW), .PAGE_BYTES(PB), .WRITE_CYCLES(WC)) u_dut (
        .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .start_addr(start_addr),
        .byte_stb(byte_stb), .byte_data(byte_data), .stop_stb(stop_stb),
        .wp_in(wp_in), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .busy(busy), .word_ptr(word_ptr)
    );

    // Array model fed by the write port; counts writes and busy cycles.
    always @(posedge clk) begin
        if (rst_n && mem_we) begin
            dut_mem[mem_addr] <= mem_wdata;
            wr_count <= wr_count + 1;
        end
        if (rst_n && busy) busy_cnt <= busy_cnt + 1;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic pulse_addr(input logic [AW-1:0] a);
        start_addr = a; addr_load = 1'b1; @(negedge clk); addr_load = 1'b0;
    endtask
    task automatic pulse_byte(input logic [7:0] d);
        byte_data = d; byte_stb = 1'b1; @(negedge clk); byte_stb = 1'b0;
    endtask
    task automatic pulse_stop();
        stop_stb = 1'b1; @(negedge clk); stop_stb = 1'b0;
    endtask

    // One write command checked against a bench model of the page latch.
    task automatic run_txn(input logic [AW-1:0] start, input int n,
                           input bit wp_stop, input bit wp_flip, input bit poke);
        logic [7:0]  lat [PB];
        bit          v [PB];
        int          distinct = 0, bad = 0;
        bit          commit;
        logic [AW-1:0] exp_ptr;
        for (int i = 0; i < PB; i++) v[i] = 1'b0;
        wr_count = 0;
        pulse_addr(start);
        for (int i = 0; i < n; i++) begin
            logic [7:0] d = 8'($urandom);
            int off = (int'(start[4:0]) + i) % PB;
            lat[off] = d; v[off] = 1'b1;
            pulse_byte(d);
        end
        // R6: no write and no busy before STOP
        chk(wr_count == 0 && !busy, "R6", "activity before stop", wr_count, 0);
        commit = (n > 0) && !wp_stop;
        wp_in = wp_stop;
        busy_cnt = 0;
        pulse_stop();
        // R6/R8/R10: busy in the cycle after STOP only when committing
        chk(busy == commit, commit ? "R6" : (n == 0 ? "R10" : "R8"),
            "busy after stop", int'(busy), int'(commit));
        if (wp_flip) wp_in = ~wp_stop;
        if (poke && commit) begin
            pulse_addr(AW'($urandom));
            pulse_byte(8'($urandom));
            pulse_stop();
        end
        for (int k = 0; k < 400 && busy; k++) @(negedge clk);
        @(negedge clk);
        wp_in = 1'b0;
        for (int i = 0; i < PB; i++) if (v[i]) distinct++;
        // R7 (R9 and R11 when toggled or poked): exact busy length
        chk(busy_cnt == (commit ? PB + WC : 0), wp_flip ? "R9" : (poke ? "R11" : "R7"),
            "busy cycles", busy_cnt, commit ? PB + WC : 0);
        // R5: one write per distinct received offset
        chk(wr_count == (commit ? distinct : 0), "R5", "write count",
            wr_count, commit ? distinct : 0);
        exp_ptr = {start[AW-1:5], 5'(int'(start[4:0]) + n)};
        // R3/R12 (R11 when poked): pointer after the command
        chk(word_ptr == exp_ptr, poke ? "R11" : "R12", "word_ptr",
            int'(word_ptr), int'(exp_ptr));
        if (commit) for (int i = 0; i < PB; i++)
            if (v[i]) exp_mem[{start[AW-1:5], 5'(i)}] = lat[i];
        for (int i = 0; i < PB; i++) begin
            logic [AW-1:0] a = {start[AW-1:5], 5'(i)};
            if (dut_mem[a] !== exp_mem[a]) bad++;
        end
        // R2/R4/R5: page contents match the model
        chk(bad == 0, n > PB ? "R4" : "R2", "page mismatches", bad, 0);
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < (1 << AW); i++) begin
            dut_mem[i] = 8'(i) ^ 8'h5A;
            exp_mem[i] = 8'(i) ^ 8'h5A;
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!busy && !mem_we && word_ptr == '0, "R1", "reset outputs",
            int'({busy, mem_we}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        run_txn(13'h0005, 1, 1'b0, 1'b0, 1'b0);   // R2, R12 single byte
        run_txn(13'h003F, 1, 1'b0, 1'b0, 1'b0);   // R3 offset wrap to page start
        run_txn(13'h1FFF, 3, 1'b0, 1'b0, 1'b0);   // R3 top page wraps in place
        run_txn(13'h0127, 40, 1'b0, 1'b0, 1'b0);  // R4 overflow overwrites
        run_txn(13'h0400, 32, 1'b0, 1'b0, 1'b0);  // R5 full page
        run_txn(13'h0200, 4, 1'b1, 1'b0, 1'b0);   // R8 protected
        run_txn(13'h0210, 5, 1'b0, 1'b1, 1'b0);   // R9 wp raised after STOP
        run_txn(13'h0220, 0, 1'b0, 1'b0, 1'b0);   // R10 address only
        run_txn(13'h0230, 6, 1'b0, 1'b0, 1'b1);   // R11 strobes while busy
        for (int t = 0; t < 10; t++)
            run_txn(AW'($urandom), int'($urandom_range(0, 45)), 1'b0, 1'b0, 1'b0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule